// File: doc/BRIEF.md
# Bridge Interrupt Status and Lock Register Block

This block collects error and event indications from a bus bridge into software-visible status registers and raises one interrupt line. It holds four registers behind a small register port: a bus error status word, an event status byte, an interrupt enable byte and a guarded system control word. Event inputs are single-cycle pulses that set sticky status bits. Software reads the status and clears it by writing.

The system control word drives the reset-out line toward the downstream bus. It comes out of reset locked. While locked, only a fixed 16-bit key written to it has any effect, and that key removes the lock. Software locks it again by writing a 1 to the lock bit. The interrupt output is a registered level. It is the OR of all enabled event status bits.

Top module: `bridge_irq_lock`

## Requirements
- R1: After reset the system word reads 0x4000 (locked, reset-out low), `rst_out_o` is 0, the error status, event status and enable registers read 0, and `irq_o` is 0.
- R2: Address 0 is the error status word. A pulse on `pci_err_evt_i[i]` sets bit 12+i: bit 15 parity error, bit 14 system error, bit 13 master abort, bit 12 target abort. Bits 11:0 read 0 and the bits stay set until cleared.
- R3: A write to address 0 clears each error bit whose write-data bit is 1 and leaves every bit written as 0 unchanged. Writing back the value just read therefore clears exactly the bits that were set.
- R4: Address 1 is the event status byte (bits 15:8 read 0). A pulse on `lb_evt_i[i]` sets bit i: 7 mailbox, 6 read abort, 5 write abort, 4 pin interrupt, 3 parity error, 2 inbound post queue, 1 DMA channel 1, 0 DMA channel 0. The bits are sticky.
- R5: A write to address 1 keeps only the event bits whose write-data bit is 1. Writing zero clears every pending event.
- R6: When an event pulse and a clearing write to the same register fall in the same cycle, the bit for that event is set after the cycle.
- R7: Address 2 is the interrupt enable byte. It is fully writable and reads back in bits 7:0, with bits 15:8 reading 0.
- R8: `irq_o` equals the OR of (event status AND enable), registered. It changes one cycle after the status or enable change that causes it, and error status bits do not drive it.
- R9: Address 3 is the system word: bit 15 is reset-out and drives `rst_out_o`, and bit 14 is the lock flag. Other bits read 0. While unlocked, a write loads both bits from the write data.
- R10: While locked, a write of 0xA05F to address 3 clears the lock and leaves reset-out unchanged. Any other write to address 3 is ignored.
- R11: While unlocked, writing 1 to bit 14 of address 3 sets the lock again in the same write that loads reset-out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register select (0 error, 1 event, 2 enable, 3 system) |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i`, combinational |
| pci_err_evt_i | input | 4 | Bus error pulses (3 parity, 2 system, 1 master abort, 0 target abort) |
| lb_evt_i | input | 8 | Event pulses, one per event status bit |
| irq_o | output | 1 | Level interrupt |
| rst_out_o | output | 1 | Reset-out control from the system word |

## Verification
A status bit can be cleared by a software write in the same cycle that its event pulse sets it. This can happen on both the error word and the event byte. The bench drives the pulse and a clearing write on one falling edge. It then reads the register back and expects the event bit set while older bits are cleared. A second overlap is between a status change and the registered interrupt, and the bench samples `irq_o` both one and two cycles after the change.

// File: rtl/bil_pkg.sv
package bil_pkg;
  localparam int unsigned REG_W = 16;

  typedef enum logic [1:0] {
    ADDR_ERR  = 2'd0,
    ADDR_EVT  = 2'd1,
    ADDR_MASK = 2'd2,
    ADDR_SYS  = 2'd3
  } reg_addr_e;

  localparam logic [REG_W-1:0] UNLOCK_KEY = 16'hA05F;
  localparam int unsigned SYS_RST_BIT  = 15;
  localparam int unsigned SYS_LOCK_BIT = 14;
endpackage

// File: rtl/bil_err_status.sv
module bil_err_status #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] evt_i,
  output logic [N-1:0] stat_o
);
  logic [N-1:0] stat_q;

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)             stat_q[g] <= 1'b0;
      else if (evt_i[g])       stat_q[g] <= 1'b1;
      else if (wr_i && clr_i[g]) stat_q[g] <= 1'b0;
    end
  end

  assign stat_o = stat_q;

  // R6
  err_evt_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_i) |=> ((stat_q & $past(evt_i)) == $past(evt_i)));

  // R3
  err_zero_keeps_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && clr_i == '0) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  // R2
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && evt_i == '0) |=> $stable(stat_q));
endmodule

// File: rtl/bil_event_irq.sv
module bil_event_irq #(
  parameter int unsigned N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         stat_wr_i,
  input  logic         mask_wr_i,
  input  logic [N-1:0] wdata_i,
  input  logic [N-1:0] evt_i,
  output logic [N-1:0] stat_o,
  output logic [N-1:0] mask_o,
  output logic         irq_o
);
  logic [N-1:0] stat_q, mask_q, stat_d;
  logic         irq_q;

  // written zeros clear; a same-cycle event still sets its bit
  always_comb begin
    stat_d = stat_q;
    if (stat_wr_i) stat_d = stat_q & wdata_i;
    stat_d = stat_d | evt_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= stat_d;
      if (mask_wr_i) mask_q <= wdata_i;
      irq_q  <= |(stat_q & mask_q);
    end
  end

  assign stat_o = stat_q;
  assign mask_o = mask_q;
  assign irq_o  = irq_q;

  // R5
  evt_zero_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_wr_i && wdata_i == '0 && evt_i == '0) |=> (stat_q == '0));

  // R6
  evt_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_i) |=> ((stat_q & $past(evt_i)) == $past(evt_i)));

  // R8
  irq_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((stat_q & mask_q) == '0) |=> !irq_o);

  // R8
  irq_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((stat_q & mask_q) != '0) |=> irq_o);
endmodule

// File: rtl/bil_sys_lock.sv
module bil_sys_lock #(
  parameter int unsigned      W        = 16,
  parameter logic [W-1:0]     KEY      = 16'hA05F,
  parameter int unsigned      RST_BIT  = 15,
  parameter int unsigned      LOCK_BIT = 14
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic         rst_out_o,
  output logic         lock_o
);
  logic rst_out_q, lock_q;
  logic key_hit;

  assign key_hit = (wdata_i == KEY);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_out_q <= 1'b0;
      lock_q    <= 1'b1;
    end else if (wr_i) begin
      if (lock_q) begin
        if (key_hit) lock_q <= 1'b0;
      end else begin
        rst_out_q <= wdata_i[RST_BIT];
        lock_q    <= wdata_i[LOCK_BIT];
      end
    end
  end

  assign rst_out_o = rst_out_q;
  assign lock_o    = lock_q;

  // R10
  locked_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q && wr_i && !key_hit) |=> ($stable(rst_out_q) && lock_q));

  // R10
  key_unlock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q && wr_i && key_hit) |=> (!lock_q && $stable(rst_out_q)));

  // R11
  relock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lock_q && wr_i && wdata_i[LOCK_BIT]) |=> lock_q);

  // R9
  no_write_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> ($stable(lock_q) && $stable(rst_out_q)));
endmodule

// File: rtl/bridge_irq_lock.sv
module bridge_irq_lock
  import bil_pkg::*;
#(
  parameter int unsigned ERR_N   = 4,
  parameter int unsigned ERR_LSB = 12,
  parameter int unsigned EVT_N   = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       addr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  input  logic [ERR_N-1:0] pci_err_evt_i,
  input  logic [EVT_N-1:0] lb_evt_i,
  output logic             irq_o,
  output logic             rst_out_o
);
  localparam int unsigned EVT_PAD = REG_W - EVT_N;

  logic             err_wr, evt_wr, mask_wr, sys_wr;
  logic [ERR_N-1:0] err_stat;
  logic [EVT_N-1:0] evt_stat, evt_mask;
  logic             lock;

  assign err_wr  = wr_en_i && (addr_i == ADDR_ERR);
  assign evt_wr  = wr_en_i && (addr_i == ADDR_EVT);
  assign mask_wr = wr_en_i && (addr_i == ADDR_MASK);
  assign sys_wr  = wr_en_i && (addr_i == ADDR_SYS);

  bil_err_status #(.N(ERR_N)) i_err (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (err_wr),
    .clr_i  (wdata_i[ERR_LSB +: ERR_N]),
    .evt_i  (pci_err_evt_i),
    .stat_o (err_stat)
  );

  bil_event_irq #(.N(EVT_N)) i_evt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .stat_wr_i (evt_wr),
    .mask_wr_i (mask_wr),
    .wdata_i   (wdata_i[EVT_N-1:0]),
    .evt_i     (lb_evt_i),
    .stat_o    (evt_stat),
    .mask_o    (evt_mask),
    .irq_o     (irq_o)
  );

  bil_sys_lock #(
    .W        (REG_W),
    .KEY      (UNLOCK_KEY),
    .RST_BIT  (SYS_RST_BIT),
    .LOCK_BIT (SYS_LOCK_BIT)
  ) i_sys (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (sys_wr),
    .wdata_i   (wdata_i),
    .rst_out_o (rst_out_o),
    .lock_o    (lock)
  );

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_ERR:  rdata_o[ERR_LSB +: ERR_N] = err_stat;
      ADDR_EVT:  rdata_o = {{EVT_PAD{1'b0}}, evt_stat};
      ADDR_MASK: rdata_o = {{EVT_PAD{1'b0}}, evt_mask};
      default: begin
        rdata_o[SYS_RST_BIT]  = rst_out_o;
        rdata_o[SYS_LOCK_BIT] = lock;
      end
    endcase
  end

  // R1
  reset_locked_chk: assert property (@(posedge clk_i)
    !rst_ni |=> (lock && !rst_out_o) || !rst_ni);
endmodule

// File: tb/test_bridge_irq_lock.sv
`timescale 1ns/1ps
module test_bridge_irq_lock;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  addr_i = 2'd0;
  logic [15:0] wdata_i = 16'h0;
  logic [15:0] rdata_o;
  logic [3:0]  pci_err_evt_i = 4'h0;
  logic [7:0]  lb_evt_i = 8'h0;
  logic        irq_o, rst_out_o;

  int n_vec = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  bridge_irq_lock i_bridge_irq_lock (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i, .rdata_o,
    .pci_err_evt_i, .lb_evt_i, .irq_o, .rst_out_o
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk_i);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic pulse(input logic [3:0] e, input logic [7:0] l);
    @(negedge clk_i);
    pci_err_evt_i = e; lb_evt_i = l;
    @(negedge clk_i);
    pci_err_evt_i = 4'h0; lb_evt_i = 8'h0;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    rd(2'd3, d); chk("R1 sys", d, 16'h4000);
    rd(2'd0, d); chk("R1 err", d, 16'h0);
    rd(2'd1, d); chk("R1 evt", d, 16'h0);
    rd(2'd2, d); chk("R1 mask", d, 16'h0);
    chk("R1 irq", {15'd0, irq_o}, 16'h0);
    chk("R1 rst_out", {15'd0, rst_out_o}, 16'h0);
  endtask

  task automatic t_err();
    logic [15:0] d;
    pulse(4'b1010, 8'h0);
    rd(2'd0, d); chk("R2 parity+master", d, 16'hA000);
    wr(2'd0, 16'h8000);
    rd(2'd0, d); chk("R3 partial w1c", d, 16'h2000);
    wr(2'd0, 16'hFFFF);
    rd(2'd0, d); chk("R3 clear all", d, 16'h0);
    pulse(4'b0101, 8'h0);
    rd(2'd0, d); chk("R2 system+target", d, 16'h5000);
    wr(2'd0, 16'h0000);
    rd(2'd0, d); chk("R3 zero write keeps", d, 16'h5000);
    wr(2'd0, d);
    rd(2'd0, d); chk("R3 write-back clears", d, 16'h0);
  endtask

  task automatic t_evt();
    logic [15:0] d;
    pulse(4'h0, 8'h81);
    rd(2'd1, d); chk("R4 mailbox+dma0", d, 16'h0081);
    pulse(4'h0, 8'h10);
    rd(2'd1, d); chk("R4 sticky", d, 16'h0091);
    wr(2'd1, 16'h0001);
    rd(2'd1, d); chk("R5 keep ones", d, 16'h0001);
    pulse(4'h0, 8'h06);
    rd(2'd1, d); chk("R4 add", d, 16'h0007);
    wr(2'd1, 16'h0000);
    rd(2'd1, d); chk("R5 zero clears", d, 16'h0);
  endtask

  task automatic t_irq();
    logic [15:0] d;
    wr(2'd2, 16'hFFAA);
    rd(2'd2, d); chk("R7 mask readback", d, 16'h00AA);
    pulse(4'h0, 8'h55);
    @(negedge clk_i);
    @(negedge clk_i);
    chk("R8 masked no irq", {15'd0, irq_o}, 16'h0);
    wr(2'd2, 16'h0001);
    chk("R8 latency low", {15'd0, irq_o}, 16'h0);
    @(negedge clk_i);
    chk("R8 irq high", {15'd0, irq_o}, 16'h1);
    pulse(4'hF, 8'h0);
    wr(2'd1, 16'h0000);
    chk("R8 still high", {15'd0, irq_o}, 16'h1);
    @(negedge clk_i);
    chk("R8 irq low, err bits ignored", {15'd0, irq_o}, 16'h0);
    wr(2'd0, 16'hF000);
  endtask

  task automatic t_collide();
    logic [15:0] d;
    pulse(4'h0, 8'h01);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = 2'd1; wdata_i = 16'h0; lb_evt_i = 8'h20;
    @(negedge clk_i);
    wr_en_i = 1'b0; lb_evt_i = 8'h0;
    rd(2'd1, d); chk("R6 event beats clear", d, 16'h0020);
    wr(2'd1, 16'h0000);
    pulse(4'b1000, 8'h0);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = 2'd0; wdata_i = 16'hF000; pci_err_evt_i = 4'b0001;
    @(negedge clk_i);
    wr_en_i = 1'b0; pci_err_evt_i = 4'h0;
    rd(2'd0, d); chk("R6 error beats w1c", d, 16'h1000);
    wr(2'd0, 16'hF000);
  endtask

  task automatic t_lock();
    logic [15:0] d;
    wr(2'd3, 16'h8000);
    rd(2'd3, d); chk("R10 locked ignore", d, 16'h4000);
    wr(2'd3, 16'hA05E);
    rd(2'd3, d); chk("R10 near key ignored", d, 16'h4000);
    wr(2'd3, 16'hA05F);
    rd(2'd3, d); chk("R10 key unlocks", d, 16'h0000);
    wr(2'd3, 16'h8000);
    rd(2'd3, d); chk("R9 set rst_out", d, 16'h8000);
    chk("R9 rst_out pin", {15'd0, rst_out_o}, 16'h1);
    wr(2'd3, 16'h0000);
    chk("R9 clear rst_out", {15'd0, rst_out_o}, 16'h0);
    wr(2'd3, 16'hC000);
    rd(2'd3, d); chk("R11 relock", d, 16'hC000);
    wr(2'd3, 16'h0000);
    rd(2'd3, d); chk("R10 relocked ignore", d, 16'hC000);
    wr(2'd3, 16'hA05F);
    rd(2'd3, d); chk("R10 unlock keeps rst_out", d, 16'h8000);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_err();
    t_evt();
    t_irq();
    t_collide();
    t_lock();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end

  initial begin
    #(5ns * 100000);
    if (!done) begin
      done = 1'b1;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end
endmodule